// File: doc/BRIEF.md
# Range-Based Access Permission Checker

This block decides, for every memory transfer presented to it, whether the transfer may proceed. It holds no range registers itself. The start address, end address and attribute word of each of a parameterized number of ranges arrive as flat configuration vectors from the register file that owns them. Each transfer carries the following:
- an address
- a requestor privilege ID
- a supervisor/user flag
- secure and debug flags
- an access kind
- a flag that marks a cache-fill read

One clock after the transfer, the block returns four results:
- a valid strobe
- an allow flag
- a one-hot code naming the kind of access that was refused
- for allowed cache-fill reads, the merged permission bits that the cache keeps beside the line

Ranges may overlap. Every range that covers the address and enables the requestor's ID must accept the transfer. The permission bits returned are the bitwise AND over all covering ranges. A single configuration bit decides the outcome for addresses that no range covers.

Top module: `range_perm_check`

## Requirements
- R1: While reset is held and on the first cycle after it, rsp_valid, rsp_allow, rsp_fault and rsp_perm are all zero.
- R2: rsp_valid rises exactly one clock after a cycle with req_valid high. In any cycle with rsp_valid low, rsp_allow, rsp_fault and rsp_perm are zero.
- R3: Range i covers the address when start page ≤ address page ≤ end page. A page is the address with its low 10 bits dropped, and the end page is inclusive.
- R4: The requestor ID enable of a range is attribute bit 10+pid for pid 0..15 and attribute bit 9 for any larger pid. A covering range whose enable is 0 places no restriction on the transfer.
- R5: The security level check passes in three cases: attribute bit 7 (open) is 1, whatever the secure and debug flags; bit 7 is 0 and the access is secure and not debug; bit 7 is 0, the access is debug and attribute bit 6 (debug allowed) is 1.
- R6: For a non-debug access, the range must also grant the access type. Attribute bits 5,4,3 grant supervisor read, write and execute. Bits 2,1,0 grant user read, write and execute. req_kind 0 is read, 1 is write, and 2 or 3 is execute. Debug accesses skip this test.
- R7: When several enabled ranges cover the address, the transfer is allowed only if every one of them passes R5 and R6.
- R8: When no range covers the address, rsp_allow equals cfg_assume_allow.
- R9: A refused transfer reports a one-hot rsp_fault:
  - 100000 for supervisor read
  - 010000 for supervisor write
  - 001000 for supervisor execute
  - 000100 for user read
  - 000010 for user write
  - 000001 for user execute
  
  An allowed transfer reports 000000.
- R10: An allowed transfer with req_cache_rd set and read kind returns rsp_perm as the AND of attribute bits 7..0 over all covering ranges, or 0xFF if none covers. Every other response returns rsp_perm = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | NR*AW | Start address of each range, range i at bits i*AW upward |
| cfg_end | input | NR*AW | End address of each range (end page inclusive) |
| cfg_attr | input | NR*32 | Attribute word of each range |
| cfg_assume_allow | input | 1 | Outcome for an address that no range covers |
| req_valid | input | 1 | Transfer present this cycle |
| req_addr | input | AW | Transfer address |
| req_pid | input | PIDW | Requestor privilege ID |
| req_super | input | 1 | 1 = supervisor, 0 = user |
| req_secure | input | 1 | Secure access |
| req_debug | input | 1 | Debug-port access |
| req_kind | input | 2 | 0 read, 1 write, 2/3 execute |
| req_cache_rd | input | 1 | Read is a cache fill |
| rsp_valid | output | 1 | Decision valid |
| rsp_allow | output | 1 | Transfer allowed |
| rsp_fault | output | 6 | One-hot refused access type |
| rsp_perm | output | 8 | Merged permission bits for cache fills |

## Verification
Only the range configuration can affect the decision from one transfer to the next, because the block carries no state apart from its output register. A wrong decode therefore shows at the ports in the very response to the transfer that exercises it, one clock later. The scenarios focus on the places where a fault would otherwise hide:
- the inclusive end page and ignored low address bits, probed right at the page boundaries
- a covering range whose ID enable is clear, tested with the uncovered default set to deny so that the two cases can be told apart
- the three security levels, including debug accesses that skip the type bits
- overlaps, where one permissive range must not mask a restrictive one

A corrupted merge shows up as a wrong rsp_perm byte on the next cache-fill read.

// File: rtl/range_perm_check.sv
module range_perm_check #(
  parameter int NR   = 4,
  parameter int AW   = 32,
  parameter int PIDW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NR*AW-1:0] cfg_start,
  input  logic [NR*AW-1:0] cfg_end,
  input  logic [NR*32-1:0] cfg_attr,
  input  logic            cfg_assume_allow,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [PIDW-1:0] req_pid,
  input  logic            req_super,
  input  logic            req_secure,
  input  logic            req_debug,
  input  logic [1:0]      req_kind,
  input  logic            req_cache_rd,
  output logic            rsp_valid,
  output logic            rsp_allow,
  output logic [5:0]      rsp_fault,
  output logic [7:0]      rsp_perm
);
  localparam int PG = 10;

  logic [NR-1:0] hit, pass;
  logic [7:0]    pbits [NR];
  logic [5:0]    need;
  logic [7:0]    merged;
  logic          allow_c;
  logic [7:0]    perm_c;
  wire           pid_low = (req_pid >> 4) == '0;
  wire           unused_addr = ^req_addr[PG-1:0];

  always_comb begin
    unique case (req_kind)
      2'd0:    need = req_super ? 6'b100000 : 6'b000100;
      2'd1:    need = req_super ? 6'b010000 : 6'b000010;
      default: need = req_super ? 6'b001000 : 6'b000001;
    endcase
  end

  for (genvar i = 0; i < NR; i++) begin : g_rng
    wire [AW-1:0] s = cfg_start[i*AW +: AW];
    wire [AW-1:0] e = cfg_end[i*AW +: AW];
    wire [31:0]   a = cfg_attr[i*32 +: 32];
    wire [15:0]   aid = a[25:10];
    wire          unused_lo = ^{s[PG-1:0], e[PG-1:0], a[31:26], a[8]};
    wire          id_ok  = pid_low ? aid[req_pid[3:0]] : a[9];
    wire          lvl_ok = a[7] | (req_debug ? a[6] : req_secure);
    wire          typ_ok = req_debug | (|(a[5:0] & need));
    assign hit[i]  = (req_addr[AW-1:PG] >= s[AW-1:PG]) && (req_addr[AW-1:PG] <= e[AW-1:PG]);
    assign pass[i] = ~(hit[i] & id_ok) | (lvl_ok & typ_ok);
    assign pbits[i] = a[7:0];
  end

  always_comb begin
    merged = 8'hFF;
    for (int i = 0; i < NR; i++)
      if (hit[i]) merged = merged & pbits[i];
  end

  assign allow_c = (|hit) ? (&pass) : cfg_assume_allow;
  assign perm_c  = (allow_c && req_cache_rd && req_kind == 2'd0) ? merged : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
      rsp_fault <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_allow <= allow_c;
      rsp_fault <= allow_c ? 6'b000000 : need;
      rsp_perm  <= perm_c;
    end
  end
endmodule

// File: rtl/range_perm_check_chk.sv
module range_perm_check_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_super,
  input logic [1:0] req_kind,
  input logic       rsp_valid,
  input logic       rsp_allow,
  input logic [5:0] rsp_fault,
  input logic [7:0] rsp_perm
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == 6'd0 && !rsp_allow && rsp_perm == 8'd0));
  p_fault_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($onehot0(rsp_fault) && (rsp_allow == (rsp_fault == 6'd0))));
  p_fault_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_super && req_kind == 2'd0) |=> (rsp_fault == 6'd0 || rsp_fault == 6'b100000));
  p_perm_denied_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_allow) |-> rsp_perm == 8'd0);
endmodule

bind range_perm_check range_perm_check_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_super(req_super),
  .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
  .rsp_fault(rsp_fault), .rsp_perm(rsp_perm)
);

// File: tb/sim_range_perm_check.sv
module sim_range_perm_check;
  localparam int NR = 4, AW = 32, PIDW = 8;
  logic clk = 0, rst_n = 0;
  logic [NR*AW-1:0] st, en;
  logic [NR*32-1:0] at;
  logic assume_ok;
  logic valid, sup, sec, dbg, crd;
  logic [AW-1:0] addr;
  logic [PIDW-1:0] pid;
  logic [1:0] kind;
  logic rv, ra;
  logic [5:0] rf;
  logic [7:0] rp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  range_perm_check #(.NR(NR), .AW(AW), .PIDW(PIDW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_start(st), .cfg_end(en), .cfg_attr(at),
    .cfg_assume_allow(assume_ok), .req_valid(valid), .req_addr(addr), .req_pid(pid),
    .req_super(sup), .req_secure(sec), .req_debug(dbg), .req_kind(kind),
    .req_cache_rd(crd), .rsp_valid(rv), .rsp_allow(ra), .rsp_fault(rf), .rsp_perm(rp));

  function automatic logic [31:0] mk(logic [15:0] aid, logic aidx, logic ns, logic emu, logic [5:0] p);
    return {6'd0, aid, aidx, 1'b0, ns, emu, p};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_rng(int i, logic [31:0] s, logic [31:0] e, logic [31:0] a);
    st[i*AW +: AW] = s; en[i*AW +: AW] = e; at[i*32 +: 32] = a;
  endtask

  task automatic clear_rngs();
    for (int i = 0; i < NR; i++) set_rng(i, 32'hFFFF_FC00, 32'h0, 32'h0);
  endtask

  task automatic xfer(string req, logic [31:0] a, logic [7:0] p, logic s, logic se, logic d,
                      logic [1:0] k, logic c, logic ea, logic [5:0] ef, logic [7:0] ep);
    @(negedge clk);
    valid = 1; addr = a; pid = p; sup = s; sec = se; dbg = d; kind = k; crd = c;
    @(negedge clk);
    valid = 0;
    check({req, " valid"}, 32'(rv), 32'd1);
    check({req, " allow"}, 32'(ra), 32'(ea));
    check({req, " fault"}, 32'(rf), 32'(ef));
    check({req, " perm"}, 32'(rp), 32'(ep));
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(rv), 0); check("R1 allow", 32'(ra), 0);
    check("R1 fault", 32'(rf), 0); check("R1 perm", 32'(rp), 0);
  endtask

  task automatic t_latency();
    xfer("R2 req", 32'h1000, 8'd1, 1, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    @(negedge clk);
    check("R2 idle valid", 32'(rv), 0);
    check("R2 idle fault", 32'(rf), 0);
  endtask

  task automatic t_match();
    xfer("R3 last byte end page", 32'h1FFF, 8'd1, 1, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    xfer("R6 sup exec denied", 32'h1000, 8'd1, 1, 0, 0, 2'd2, 0, 0, 6'b001000, 8'd0);
    xfer("R6 user read denied", 32'h1FF0, 8'd1, 0, 0, 0, 2'd0, 0, 0, 6'b000100, 8'd0);
    xfer("R3 below start", 32'h0FFF, 8'd1, 0, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    xfer("R3 past end", 32'h2000, 8'd1, 0, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
  endtask

  task automatic t_ids();
    assume_ok = 0;
    xfer("R8 uncovered denied", 32'h8000, 8'd1, 1, 0, 0, 2'd0, 0, 0, 6'b100000, 8'd0);
    xfer("R4 id disabled unchecked", 32'h1800, 8'd2, 0, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    xfer("R4 high id aidx=0", 32'h1800, 8'd20, 0, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    set_rng(0, 32'h1000, 32'h1C00, mk(16'h0002, 1, 1, 0, 6'b110000));
    xfer("R4 high id aidx=1", 32'h1800, 8'd20, 0, 0, 0, 2'd0, 0, 0, 6'b000100, 8'd0);
    assume_ok = 1;
  endtask

  task automatic t_level();
    clear_rngs();
    set_rng(1, 32'h4000, 32'h4000, mk(16'hFFFF, 1, 0, 0, 6'h3F));
    xfer("R5 secure ok", 32'h43FF, 8'd3, 1, 1, 0, 2'd1, 0, 1, 6'd0, 8'd0);
    xfer("R5 nonsecure denied", 32'h4000, 8'd3, 1, 0, 0, 2'd1, 0, 0, 6'b010000, 8'd0);
    xfer("R5 debug emu=0 denied", 32'h4000, 8'd3, 1, 1, 1, 2'd0, 0, 0, 6'b100000, 8'd0);
    set_rng(1, 32'h4000, 32'h4000, mk(16'hFFFF, 1, 0, 1, 6'h00));
    xfer("R6 debug skips type", 32'h4000, 8'd3, 0, 0, 1, 2'd1, 0, 1, 6'd0, 8'd0);
    xfer("R6 secure no type bit", 32'h4000, 8'd3, 0, 1, 0, 2'd1, 0, 0, 6'b000010, 8'd0);
    set_rng(1, 32'h4000, 32'h4000, mk(16'hFFFF, 1, 1, 0, 6'h3F));
    xfer("R5 open nonsecure", 32'h4000, 8'd3, 0, 0, 0, 2'd2, 0, 1, 6'd0, 8'd0);
    xfer("R5 open debug emu ignored", 32'h4000, 8'd3, 0, 0, 1, 2'd0, 0, 1, 6'd0, 8'd0);
  endtask

  task automatic t_overlap();
    clear_rngs();
    set_rng(0, 32'h1000, 32'h1C00, mk(16'hFFFF, 1, 1, 1, 6'b110110));
    set_rng(2, 32'h1800, 32'h2400, mk(16'hFFFF, 1, 1, 0, 6'b101101));
    xfer("R10 overlap cache read", 32'h1900, 8'd0, 1, 0, 0, 2'd0, 1, 1, 6'd0, 8'hA4);
    xfer("R7 overlap write denied", 32'h1900, 8'd0, 1, 0, 0, 2'd1, 0, 0, 6'b010000, 8'd0);
    xfer("R7 single range write", 32'h1500, 8'd0, 1, 0, 0, 2'd1, 0, 1, 6'd0, 8'd0);
    xfer("R10 single cache read", 32'h1500, 8'd0, 0, 0, 0, 2'd0, 1, 1, 6'd0, 8'hF6);
    xfer("R10 uncovered cache read", 32'h9000, 8'd0, 1, 0, 0, 2'd0, 1, 1, 6'd0, 8'hFF);
    xfer("R10 plain read no perm", 32'h1500, 8'd0, 1, 0, 0, 2'd0, 0, 1, 6'd0, 8'd0);
    xfer("R10 cache flag on write", 32'h1500, 8'd0, 1, 0, 0, 2'd1, 1, 1, 6'd0, 8'd0);
    xfer("R6 kind 3 is execute", 32'h1900, 8'd0, 0, 0, 0, 2'd3, 0, 0, 6'b000001, 8'd0);
    assume_ok = 0;
    xfer("R8 uncovered cache denied", 32'h9000, 8'd0, 1, 0, 0, 2'd0, 1, 0, 6'b100000, 8'd0);
  endtask

  initial begin
    valid = 0; addr = 0; pid = 0; sup = 0; sec = 0; dbg = 0; kind = 0; crd = 0;
    assume_ok = 1;
    clear_rngs();
    set_rng(0, 32'h1000, 32'h1C00, mk(16'h0002, 0, 1, 0, 6'b110000));
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_match();
    t_ids();
    t_level();
    t_overlap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule